// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This block collects the event pulses of an SD host controller into sticky status bits and turns them into one interrupt line for the CPU. The command, data and card-detect logic each raise a one-cycle pulse. The matching status bit then stays set until software clears it. Software clears a bit by writing 0 to it, so an acknowledge is a write of the inverted event set. A 32-bit mask register selects which sticky bits may raise the interrupt.

The unit also reflects two level signals live in the status word: the synchronised card-present input and the write-protect input. The card-present level produces insert and remove events on its edges.

A separate 16-bit status and mask pair holds the card I/O interrupt. This pair reaches the CPU line only while an enable bit in a transaction-control register is set. A flat register port gives access to all registers. The port writes on a strobe and reads combinationally.

Top module: `sd_irq_unit`

## Requirements
- R1: After reset, the main status reads 0, the main mask reads 0xFFFFFFFF, the I/O status reads 0, the I/O mask reads 0xFFFF, transaction control reads 0, and irq_o is 0.
- R2: A pulse on evt_i[k] sets main status bit k+2 at the next clock edge. The bit stays set until it is cleared. Bits 2..11 are, in order: command response end, command timeout, data end, CRC fail, data timeout, RX overflow, TX underrun, RX ready, TX request and illegal access.
- R3: A write to main status (address 0) clears each bit written as 0. Each bit written as 1 is left unchanged.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: A mask bit of 1 blocks its status bit. irq_o is 1 whenever any sticky status bit (0..11) is set and its mask bit is 0. Main mask is address 1.
- R6: cd_i passes through a 2-flop synchroniser. Status bit 16 shows the synchronised level two edges after cd_i changes. A rising level sets sticky bit 1 (insert) one edge later, and a falling level sets sticky bit 0 (remove) one edge later.
- R7: Status bit 17 follows wp_i directly. Writes to the status register have no effect on this bit.
- R8: Main status bits 12..15 and 18..31 always read 0 and never raise irq_o, even with the whole mask cleared. Bits 16 and 17 never raise irq_o.
- R9: A pulse on sdio_evt_i sets I/O status bit 0 (address 2). The bit clears when it is written as 0. Its mask is bit 0 of address 3, and the value 1 blocks it.
- R10: A pending, unmasked I/O status bit drives irq_o only while bit 0 of transaction control (address 4) is 1.
- R11: Reads of addresses 5..7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | Event pulses for status bits 2..11 |
| sdio_evt_i | input | 1 | Card I/O interrupt pulse |
| cd_i | input | 1 | Raw card-present level (asynchronous) |
| wp_i | input | 1 | Write-protect level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |
| irq_o | output | 1 | Combined interrupt to the CPU |

## Verification
The bench goes after the cycle where a pulse and a clearing write hit the same bit. A design that lets the clear win would silently lose that event. It also writes all ones to the status register. A design that treated the write as a plain store, or as write-one-to-clear, would then change bits it should keep. The card-detect checks sample exactly two and three edges after cd_i moves, which catches a missing or extra synchroniser stage and an edge detector of the wrong polarity. The I/O path is checked unmasked but disabled, which catches an enable gate that is missing.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned IO_W     = 16;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned EVT_W    = 10;

  localparam int unsigned BIT_CARD_RM  = 0;
  localparam int unsigned BIT_CARD_IN  = 1;
  localparam int unsigned BIT_EVT_LO   = 2;
  localparam int unsigned BIT_CD_LVL   = 16;
  localparam int unsigned BIT_WP_LVL   = 17;

  localparam logic [REG_W-1:0] STICKY_MASK = (REG_W'(1) << (BIT_EVT_LO + EVT_W)) - REG_W'(1);
  localparam logic [IO_W-1:0]  IO_IMPL     = 16'h0001;
  localparam logic [IO_W-1:0]  XACT_IMPL   = 16'h0001;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT    = 3'd0,
    A_MASK    = 3'd1,
    A_IO_STAT = 3'd2,
    A_IO_MASK = 3'd3,
    A_XACT    = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/sd_sticky_reg.sv
module sd_sticky_reg #(
  parameter int unsigned          W    = 32,
  parameter logic [W-1:0]         IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, kept;

  always_comb begin
    kept = we_i ? (q_o & wdata_i) : q_o;
    q_d  = (kept | set_i) & IMPL;   // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & IMPL)) |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL))); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & ~$past(q_o) & ~$past(set_i)) == '0)); // R2
  AST_ZERO_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o & ~$past(wdata_i) & ~$past(set_i)) == '0)); // R3
  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_o & ~IMPL) == '0)); // R8
endmodule

// File: rtl/sd_cfg_reg.sv
module sd_cfg_reg #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] RST  = '1,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST & IMPL;
    else if (we_i) q_o <= wdata_i & IMPL;
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o)); // R5
endmodule

// File: rtl/sd_cd_sync.sv
module sd_cd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cd_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= cd_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[s] <= 1'b0;
          else         sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  AST_CD_EDGE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o})); // R6
  AST_CD_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/sd_irq_unit.sv
module sd_irq_unit
  import sd_irq_pkg::*;
#(
  parameter int unsigned CD_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              sdio_evt_i,
  input  logic              cd_i,
  input  logic              wp_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic             cd_lvl, cd_rise, cd_fall;
  logic [REG_W-1:0] stat_set, stat_q, mask_q, live;
  logic [IO_W-1:0]  io_set, io_stat_q, io_mask_q, xact_q;
  logic             we_stat, we_mask, we_io_stat, we_io_mask, we_xact;
  logic             main_pend, io_pend;

  sd_cd_sync #(.STAGES(CD_STAGES)) i_cd_sync (
    .clk_i, .rst_ni, .cd_i,
    .level_o(cd_lvl), .rise_o(cd_rise), .fall_o(cd_fall)
  );

  always_comb begin
    we_stat    = reg_we_i && (reg_addr_i == A_STAT);
    we_mask    = reg_we_i && (reg_addr_i == A_MASK);
    we_io_stat = reg_we_i && (reg_addr_i == A_IO_STAT);
    we_io_mask = reg_we_i && (reg_addr_i == A_IO_MASK);
    we_xact    = reg_we_i && (reg_addr_i == A_XACT);
  end

  always_comb begin
    stat_set = '0;
    stat_set[BIT_CARD_RM] = cd_fall;
    stat_set[BIT_CARD_IN] = cd_rise;
    stat_set[BIT_EVT_LO +: EVT_W] = evt_i;
    io_set    = '0;
    io_set[0] = sdio_evt_i;
  end

  sd_sticky_reg #(.W(REG_W), .IMPL(STICKY_MASK)) i_stat (
    .clk_i, .rst_ni, .set_i(stat_set), .we_i(we_stat),
    .wdata_i(reg_wdata_i), .q_o(stat_q)
  );

  sd_cfg_reg #(.W(REG_W), .RST('1), .IMPL(STICKY_MASK | ~STICKY_MASK)) i_mask (
    .clk_i, .rst_ni, .we_i(we_mask), .wdata_i(reg_wdata_i), .q_o(mask_q)
  );

  sd_sticky_reg #(.W(IO_W), .IMPL(IO_IMPL)) i_io_stat (
    .clk_i, .rst_ni, .set_i(io_set), .we_i(we_io_stat),
    .wdata_i(reg_wdata_i[IO_W-1:0]), .q_o(io_stat_q)
  );

  sd_cfg_reg #(.W(IO_W), .RST('1), .IMPL('1)) i_io_mask (
    .clk_i, .rst_ni, .we_i(we_io_mask), .wdata_i(reg_wdata_i[IO_W-1:0]), .q_o(io_mask_q)
  );

  sd_cfg_reg #(.W(IO_W), .RST('0), .IMPL(XACT_IMPL)) i_xact (
    .clk_i, .rst_ni, .we_i(we_xact), .wdata_i(reg_wdata_i[IO_W-1:0]), .q_o(xact_q)
  );

  always_comb begin
    live = '0;
    live[BIT_CD_LVL] = cd_lvl;
    live[BIT_WP_LVL] = wp_i;
  end

  always_comb begin
    main_pend = |(stat_q & ~mask_q & STICKY_MASK);
    io_pend   = xact_q[0] & (|(io_stat_q & ~io_mask_q & IO_IMPL));
    irq_o     = main_pend | io_pend;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_STAT:    reg_rdata_o = stat_q | live;
      A_MASK:    reg_rdata_o = mask_q;
      A_IO_STAT: reg_rdata_o = {{(REG_W-IO_W){1'b0}}, io_stat_q};
      A_IO_MASK: reg_rdata_o = {{(REG_W-IO_W){1'b0}}, io_mask_q};
      A_XACT:    reg_rdata_o = {{(REG_W-IO_W){1'b0}}, xact_q};
      default:   reg_rdata_o = '0;
    endcase
  end

  AST_IO_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xact_q[0] && !main_pend) |-> !irq_o); // R10
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&mask_q) && !io_pend) |-> !irq_o); // R5
  AST_READ_HOLES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_STAT) |-> ((reg_rdata_o & ~(STICKY_MASK | live)) == '0)); // R8
endmodule

// File: tb/test_sd_irq_unit.sv
module test_sd_irq_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  evt_i = '0;
  logic        sdio_evt_i = 1'b0;
  logic        cd_i = 1'b0;
  logic        wp_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4ns clk_i = ~clk_i;

  sd_irq_unit i_sd_irq_unit (
    .clk_i, .rst_ni, .evt_i, .sdio_evt_i, .cd_i, .wp_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  typedef struct packed {
    logic [9:0]  evt;
    logic        we;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_stat;
    logic        exp_irq;
  } vec_t;

  // R2 R3 R4 R5 walk
  localparam vec_t VECS [11] = '{
    '{evt:10'h001, we:1'b0, addr:3'd0, wdata:32'h0,         exp_stat:32'h004, exp_irq:1'b0},
    '{evt:10'h000, we:1'b1, addr:3'd1, wdata:32'hFFFF_FFFB, exp_stat:32'h004, exp_irq:1'b1},
    '{evt:10'h004, we:1'b0, addr:3'd0, wdata:32'h0,         exp_stat:32'h014, exp_irq:1'b1},
    '{evt:10'h000, we:1'b1, addr:3'd0, wdata:32'hFFFF_FFFB, exp_stat:32'h010, exp_irq:1'b0},
    '{evt:10'h000, we:1'b1, addr:3'd1, wdata:32'hFFFF_FFEB, exp_stat:32'h010, exp_irq:1'b1},
    '{evt:10'h000, we:1'b1, addr:3'd0, wdata:32'hFFFF_FFFF, exp_stat:32'h010, exp_irq:1'b1},
    '{evt:10'h010, we:1'b1, addr:3'd0, wdata:32'hFFFF_FFEF, exp_stat:32'h040, exp_irq:1'b0},
    '{evt:10'h001, we:1'b1, addr:3'd0, wdata:32'hFFFF_FFFB, exp_stat:32'h044, exp_irq:1'b1},
    '{evt:10'h3FF, we:1'b0, addr:3'd0, wdata:32'h0,         exp_stat:32'hFFC, exp_irq:1'b1},
    '{evt:10'h000, we:1'b1, addr:3'd0, wdata:32'h0,         exp_stat:32'h000, exp_irq:1'b0},
    '{evt:10'h000, we:1'b1, addr:3'd1, wdata:32'h0,         exp_stat:32'h000, exp_irq:1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1ns;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  initial begin
    #150us;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd(3'd0, d); chk("R1 status", d, 32'h0);
    rd(3'd1, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R1 io status", d, 32'h0);
    rd(3'd3, d); chk("R1 io mask", d, 32'h0000_FFFF);
    rd(3'd4, d); chk("R1 xact", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < 11; i++) begin
      @(negedge clk_i);
      evt_i = VECS[i].evt; reg_we_i = VECS[i].we;
      reg_addr_i = VECS[i].addr; reg_wdata_i = VECS[i].wdata;
      @(negedge clk_i);
      evt_i = '0; reg_we_i = 1'b0;
      rd(3'd0, d);
      chk($sformatf("R2/R3/R4 status vec %0d", i), d, VECS[i].exp_stat);
      chk($sformatf("R5 irq vec %0d", i), {31'b0, irq_o}, {31'b0, VECS[i].exp_irq});
    end

    // R8 holes read zero, mask fully open, irq quiet
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R8 holes", d, 32'h0);
    chk("R8 irq", {31'b0, irq_o}, 32'h0);
    rd(3'd5, d); chk("R11 addr5", d, 32'h0);
    rd(3'd7, d); chk("R11 addr7", d, 32'h0);

    // R6 card detect
    @(negedge clk_i); cd_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rd(3'd0, d); chk("R6 level after 2", d, 32'h0001_0000);
    @(negedge clk_i);
    rd(3'd0, d); chk("R6 insert after 3", d, 32'h0001_0002);
    chk("R6 irq insert", {31'b0, irq_o}, 32'h1);
    wr(3'd0, 32'hFFFF_FFFD);
    rd(3'd0, d); chk("R6 insert cleared", d, 32'h0001_0000);
    cd_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rd(3'd0, d); chk("R6 remove", d, 32'h0000_0001);
    chk("R6 irq remove", {31'b0, irq_o}, 32'h1);
    wr(3'd0, 32'h0);

    // R7 write-protect live
    wp_i = 1'b1;
    rd(3'd0, d); chk("R7 wp live", d, 32'h0002_0000);
    chk("R8 live no irq", {31'b0, irq_o}, 32'h0);
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R7 wp after write", d, 32'h0002_0000);
    wp_i = 1'b0;
    rd(3'd0, d); chk("R7 wp drop", d, 32'h0);

    // R9 R10 card I/O path
    wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk_i); sdio_evt_i = 1'b1;
    @(negedge clk_i); sdio_evt_i = 1'b0;
    rd(3'd2, d); chk("R9 io set", d, 32'h1);
    chk("R9 io masked", {31'b0, irq_o}, 32'h0);
    wr(3'd3, 32'h0000_FFFE);
    chk("R10 disabled", {31'b0, irq_o}, 32'h0);
    wr(3'd4, 32'h1);
    rd(3'd4, d); chk("R10 xact", d, 32'h1);
    chk("R10 enabled", {31'b0, irq_o}, 32'h1);
    wr(3'd2, 32'h0000_FFFF);
    rd(3'd2, d); chk("R9 io keep on one", d, 32'h1);
    wr(3'd2, 32'h0000_FFFE);
    rd(3'd2, d); chk("R9 io clear", d, 32'h0);
    chk("R10 cleared", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule